// File: doc/BRIEF.md
# Flash command interface state machine

This block is a cycle-based behavioural model of the command front end and write automation of a byte-wide nonvolatile memory whose array is split into equal blocks that are erased separately. A host reaches it over an SRAM-style bus: active-low chip enable, write enable and output enable, plus address and data. Commands written on that bus start byte programming, block erasure, erase suspension and resumption, status clearing, and changes of read mode.

The array is a small register file. Erasing a block sets every byte in it to 0xFF. Programming can only clear bits. A ready/busy output shows when the internal sequencer is running, and a status register reports the result of each operation. Loss of programming voltage, or an active-low powerdown input, cuts off a running operation and leaves its target partly changed. Busy durations come from parameters, so ready/busy timing and abort effects can be checked cycle by cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the array reads 0xFF everywhere, ready/busy is high, and the read mode is array read. The command 0xFF selects array read, and 0x70 selects status read.
- R2: The status byte holds: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 write error, bit 3 programming voltage low. Bits 2..0 read 0. Every operation that is accepted leaves the block in status-read mode.
- R3: A program sequence is command 0x40 followed by one write of address and data. Once it completes, the byte holds its old value AND the written data.
- R4: Ready/busy goes low in the cycle after the data write or confirm is accepted. It stays low for WR_CYC cycles for a byte write and for BLK_BYTES cycles for an erase.
- R5: An erase is command 0x20 followed by 0xD0. The block erased is the one containing the address of the confirm write. After completion every byte of that block reads 0xFF and other blocks are unchanged.
- R6: Any write other than 0xD0 after 0x20 sets status bits 5 and 4 together, erases nothing and leaves ready/busy high.
- R7: A program or erase confirmed while vpp_ok_i is low does not start. Ready/busy stays high, the matching error bit and bit 3 are set, and the array is unchanged.
- R8: Command 0xB0 during an erase suspends it. Ready/busy goes high, status reads 0xC0, and other blocks can be read. Command 0xD0 resumes the erase, which then finishes the remaining bytes.
- R9: If vpp_ok_i is low in any busy cycle, the operation is aborted, even in its final cycle. An aborted byte write leaves old AND (data OR 0xF0). An aborted erase leaves only the bytes already swept (from offset 0 upward) at 0xFF. The matching error bit and bit 3 are set.
- R10: While pwr_dn_ni is low, ready/busy is high, data_o is 0 and writes are ignored. A running operation is aborted as in R9, but no status bit is set. The status error bits are cleared, and on leaving powerdown the mode is array read.
- R11: Command 0x50 clears status bits 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_dn_ni | input | 1 | Deep powerdown, active low |
| vpp_ok_i | input | 1 | Programming voltage present |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; sampled each clock |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Command or program data |
| data_o | output | 8 | Array byte or status byte |
| rdy_o | output | 1 | Ready (1) or busy (0) |

## Verification
Two events can land in the same clock cycle: the final cycle of a byte write and a drop of programming voltage. The bench lowers vpp_ok_i exactly WR_CYC-1 cycles after the data write, so the drop is sampled on the edge where the write would complete. It then judges the outcome from the partial byte pattern (old AND (data OR 0xF0)) and from status 0x98. An erase that is suspended mid-sweep and a powerdown that lands mid-erase are judged in the same way, by which byte offsets read 0xFF afterwards.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_SETUP, ST_ER_SETUP, ST_WR_BUSY, ST_ER_BUSY, ST_ER_SUSP
  } fc_state_e;

  localparam logic [7:0] CMD_RD_ARR  = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT = 8'h70;
  localparam logic [7:0] CMD_CLR     = 8'h50;
  localparam logic [7:0] CMD_WR      = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;
  localparam logic [7:0] ABORT_KEEP  = 8'hF0;
endpackage

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pgm_en_i,
  input  logic [ADDR_W-1:0]     pgm_addr_i,
  input  logic [7:0]            pgm_data_i,
  input  logic                  ers_en_i,
  input  logic [ADDR_W-1:0]     ers_addr_i,
  output logic [DEPTH-1:0][7:0] mem_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       mem_o[g] <= 8'hFF;
      else if (ers_en_i && ers_addr_i == ADDR_W'(g))     mem_o[g] <= 8'hFF;
      else if (pgm_en_i && pgm_addr_i == ADDR_W'(g))     mem_o[g] <= mem_o[g] & pgm_data_i;
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFF_W     = 4,
  parameter int BLK_BYTES = 16,
  parameter int WR_CYC    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_i,
  input  logic              vpp_ok_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              pgm_en_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [7:0]        pgm_data_o,
  output logic              ers_en_o,
  output logic [ADDR_W-1:0] ers_addr_o,
  output logic              rd_stat_o,
  output logic [7:0]        sts_o,
  output fc_state_e         st_o
);
  localparam int WCW   = $clog2(WR_CYC + 1);
  localparam int CNT_W = (OFF_W > WCW) ? OFF_W : WCW;
  localparam logic [CNT_W-1:0] ERS_LAST = CNT_W'(BLK_BYTES - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_CYC - 1);

  fc_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;
  logic              rd_stat_q, ers_err_q, wr_err_q, vpp_low_q;
  logic              busy, abort;

  assign busy  = (st_q == ST_WR_BUSY) || (st_q == ST_ER_BUSY);
  assign abort = busy && (pd_i || !vpp_ok_i);

  always_comb begin
    pgm_en_o   = 1'b0;
    pgm_addr_o = op_addr_q;
    pgm_data_o = op_data_q;
    ers_en_o   = 1'b0;
    ers_addr_o = {op_addr_q[ADDR_W-1:OFF_W], cnt_q[OFF_W-1:0]};
    if (st_q == ST_WR_BUSY) begin
      if (abort) begin
        pgm_en_o   = 1'b1;
        pgm_data_o = op_data_q | ABORT_KEEP;  // partial program
      end else if (cnt_q == '0) begin
        pgm_en_o = 1'b1;
      end
    end
    if (st_q == ST_ER_BUSY && !abort) ers_en_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; op_addr_q <= '0; op_data_q <= '0;
      rd_stat_q <= 1'b0; ers_err_q <= 1'b0; wr_err_q <= 1'b0; vpp_low_q <= 1'b0;
    end else if (pd_i) begin
      st_q <= ST_IDLE; rd_stat_q <= 1'b0;
      ers_err_q <= 1'b0; wr_err_q <= 1'b0; vpp_low_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (wr_stb_i) begin
          case (data_i)
            CMD_RD_ARR:  rd_stat_q <= 1'b0;
            CMD_RD_STAT: rd_stat_q <= 1'b1;
            CMD_CLR:     begin ers_err_q <= 1'b0; wr_err_q <= 1'b0; vpp_low_q <= 1'b0; end
            CMD_WR:      st_q <= ST_WR_SETUP;
            CMD_ERASE:   st_q <= ST_ER_SETUP;
            default: ;
          endcase
        end
        ST_WR_SETUP: if (wr_stb_i) begin
          op_addr_q <= addr_i; op_data_q <= data_i; rd_stat_q <= 1'b1;
          if (!vpp_ok_i) begin
            wr_err_q <= 1'b1; vpp_low_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            st_q <= ST_WR_BUSY; cnt_q <= WR_LOAD;
          end
        end
        ST_ER_SETUP: if (wr_stb_i) begin
          rd_stat_q <= 1'b1;
          if (data_i != CMD_CONFIRM) begin
            ers_err_q <= 1'b1; wr_err_q <= 1'b1; st_q <= ST_IDLE;
          end else if (!vpp_ok_i) begin
            ers_err_q <= 1'b1; vpp_low_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            op_addr_q <= addr_i; cnt_q <= '0; st_q <= ST_ER_BUSY;
          end
        end
        ST_WR_BUSY:
          if (!vpp_ok_i) begin
            wr_err_q <= 1'b1; vpp_low_q <= 1'b1; st_q <= ST_IDLE;
          end else if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        ST_ER_BUSY:
          if (!vpp_ok_i) begin
            ers_err_q <= 1'b1; vpp_low_q <= 1'b1; st_q <= ST_IDLE;
          end else if (cnt_q == ERS_LAST) st_q <= ST_IDLE;  // completion beats suspend
          else begin
            cnt_q <= cnt_q + 1'b1;
            if (wr_stb_i && data_i == CMD_SUSP) st_q <= ST_ER_SUSP;
          end
        ST_ER_SUSP: if (wr_stb_i) begin
          case (data_i)
            CMD_RD_ARR:  rd_stat_q <= 1'b0;
            CMD_RD_STAT: rd_stat_q <= 1'b1;
            CMD_CONFIRM: begin rd_stat_q <= 1'b1; st_q <= ST_ER_BUSY; end
            default: ;
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_stat_o = rd_stat_q;
  assign st_o      = st_q;
  assign sts_o     = {!busy, st_q == ST_ER_SUSP, ers_err_q, wr_err_q, vpp_low_q, 3'b000};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLK   = 16,
  parameter int BLK_BYTES = 16,
  parameter int WR_CYC    = 8,
  localparam int DEPTH    = NUM_BLK * BLK_BYTES,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int OFF_W    = $clog2(BLK_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_dn_ni,
  input  logic              vpp_ok_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              rdy_o
);
  logic                  pd, wr_stb, pgm_en, ers_en, rd_stat;
  logic [ADDR_W-1:0]     pgm_addr, ers_addr;
  logic [7:0]            pgm_data, sts;
  logic [DEPTH-1:0][7:0] mem;
  fc_state_e             st;

  assign pd     = !pwr_dn_ni;
  assign wr_stb = !ce_ni && !we_ni && !pd;

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_BYTES(BLK_BYTES), .WR_CYC(WR_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .pd_i(pd), .vpp_ok_i, .wr_stb_i(wr_stb), .addr_i, .data_i,
    .pgm_en_o(pgm_en), .pgm_addr_o(pgm_addr), .pgm_data_o(pgm_data),
    .ers_en_o(ers_en), .ers_addr_o(ers_addr), .rd_stat_o(rd_stat),
    .sts_o(sts), .st_o(st)
  );

  flash_cmd_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .pgm_en_i(pgm_en), .pgm_addr_i(pgm_addr), .pgm_data_i(pgm_data),
    .ers_en_i(ers_en), .ers_addr_i(ers_addr), .mem_o(mem)
  );

  assign rdy_o  = pd || sts[7];
  assign data_o = (pd || ce_ni || oe_ni) ? 8'h00 : (rd_stat ? sts : mem[addr_i]);
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic      clk_i,
  input logic      rst_ni,
  input logic      pwr_dn_ni,
  input logic      vpp_ok_i,
  input logic      ce_ni,
  input logic      we_ni,
  input logic [7:0] data_i,
  input logic      rdy_o,
  input fc_state_e st,
  input logic [7:0] sts
);
  logic stb;
  assign stb = !ce_ni && !we_ni && pwr_dn_ni;

  assert_rdy_in_pd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_dn_ni |-> rdy_o);

  assert_rdy_in_susp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_ER_SUSP |-> rdy_o && sts[6]);

  assert_busy_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(stb));

  assert_no_start_novpp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WR_SETUP && stb && !vpp_ok_i) |=> rdy_o && sts[4] && sts[3]);

  assert_bad_confirm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ER_SETUP && stb && data_i != CMD_CONFIRM) |=> sts[5] && sts[4] && rdy_o);

  assert_vpp_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_WR_BUSY || st == ST_ER_BUSY) && !vpp_ok_i && pwr_dn_ni) |=> st == ST_IDLE && sts[3]);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_dn_ni(pwr_dn_ni), .vpp_ok_i(vpp_ok_i),
  .ce_ni(ce_ni), .we_ni(we_ni), .data_i(data_i), .rdy_o(rdy_o), .st(st), .sts(sts)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int NB = 4, BB = 16, WC = 6, AW = $clog2(NB * BB);

  logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1, vpp = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic rdy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.NUM_BLK(NB), .BLK_BYTES(BB), .WR_CYC(WC)) u_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_dn_ni(pd_n), .vpp_ok_i(vpp), .ce_ni(ce_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .data_i(din), .data_o(dout), .rdy_o(rdy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b0; addr = a; #1 v = dout; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rdy", {7'd0, rdy}, 8'h01);
    rd(6'h00, v); check("R1 array", v, 8'hFF);
    wr(6'h00, 8'h70); rd(6'h00, v); check("R2 status", v, 8'h80);
  endtask

  task automatic t_write;
    logic [7:0] v;
    wr(6'h00, 8'h40); wr(6'h13, 8'hA5);
    check("R4 busy start", {7'd0, rdy}, 8'h00);
    repeat (WC - 1) @(negedge clk);
    check("R4 busy last", {7'd0, rdy}, 8'h00);
    @(negedge clk); check("R4 ready", {7'd0, rdy}, 8'h01);
    rd(6'h00, v); check("R2 status after write", v, 8'h80);
    wr(6'h00, 8'h40); wr(6'h13, 8'h5A);
    repeat (WC) @(negedge clk);
    wr(6'h00, 8'h40); wr(6'h07, 8'h3C);
    repeat (WC) @(negedge clk);
    wr(6'h00, 8'hFF); rd(6'h13, v); check("R3 and", v, 8'h00);
    rd(6'h07, v); check("R3 byte", v, 8'h3C);
  endtask

  task automatic t_erase;
    logic [7:0] v;
    int bad = 0;
    wr(6'h10, 8'h20); wr(6'h15, 8'hD0);
    repeat (BB - 1) @(negedge clk);
    check("R4 erase busy last", {7'd0, rdy}, 8'h00);
    @(negedge clk); check("R4 erase ready", {7'd0, rdy}, 8'h01);
    wr(6'h00, 8'hFF);
    for (int i = 0; i < BB; i++) begin
      rd(AW'(16 + i), v); if (v != 8'hFF) bad++;
    end
    check("R5 block ff", 8'(bad), 8'h00);
    rd(6'h07, v); check("R5 other block", v, 8'h3C);
  endtask

  task automatic t_bad_confirm;
    logic [7:0] v;
    wr(6'h20, 8'h20); wr(6'h20, 8'h70);
    check("R6 rdy", {7'd0, rdy}, 8'h01);
    rd(6'h00, v); check("R6 status", v, 8'hB0);
    wr(6'h00, 8'h50); rd(6'h00, v); check("R11 clear", v, 8'h80);
  endtask

  task automatic t_novpp;
    logic [7:0] v;
    vpp = 1'b0;
    wr(6'h00, 8'h40); wr(6'h07, 8'h00);
    check("R7 rdy", {7'd0, rdy}, 8'h01);
    rd(6'h00, v); check("R7 write status", v, 8'h98);
    wr(6'h00, 8'h50);
    wr(6'h00, 8'h20); wr(6'h00, 8'hD0);
    rd(6'h00, v); check("R7 erase status", v, 8'hA8);
    vpp = 1'b1; wr(6'h00, 8'h50); wr(6'h00, 8'hFF);
    rd(6'h07, v); check("R7 array kept", v, 8'h3C);
  endtask

  task automatic t_suspend;
    logic [7:0] v;
    wr(6'h00, 8'h40); wr(6'h30, 8'h11); repeat (WC) @(negedge clk);
    wr(6'h00, 8'h40); wr(6'h25, 8'h00); repeat (WC) @(negedge clk);
    wr(6'h20, 8'h20); wr(6'h20, 8'hD0);
    repeat (3) @(negedge clk);
    wr(6'h00, 8'hB0);
    check("R8 rdy", {7'd0, rdy}, 8'h01);
    rd(6'h00, v); check("R8 status", v, 8'hC0);
    wr(6'h00, 8'hFF);
    rd(6'h30, v); check("R8 other block", v, 8'h11);
    rd(6'h25, v); check("R8 paused", v, 8'h00);
    wr(6'h20, 8'hD0);
    check("R8 resumed busy", {7'd0, rdy}, 8'h00);
    repeat (BB) @(negedge clk);
    check("R8 done", {7'd0, rdy}, 8'h01);
    wr(6'h00, 8'hFF); rd(6'h25, v); check("R8 finished", v, 8'hFF);
  endtask

  task automatic t_vpp_abort_last;
    logic [7:0] v;
    wr(6'h00, 8'h40); wr(6'h08, 8'h00);
    repeat (WC - 1) @(negedge clk);
    vpp = 1'b0;
    @(negedge clk); vpp = 1'b1;
    check("R9 rdy", {7'd0, rdy}, 8'h01);
    rd(6'h00, v); check("R9 status", v, 8'h98);
    wr(6'h00, 8'h50); wr(6'h00, 8'hFF);
    rd(6'h08, v); check("R9 partial byte", v, 8'hF0);
  endtask

  task automatic t_powerdown;
    logic [7:0] v;
    wr(6'h00, 8'h40); wr(6'h3A, 8'h00); repeat (WC) @(negedge clk);
    wr(6'h00, 8'h20); wr(6'h00, 8'h50);  // leaves error bits set
    wr(6'h30, 8'h20); wr(6'h30, 8'hD0);
    repeat (5) @(negedge clk);
    pd_n = 1'b0; #1;
    check("R10 rdy", {7'd0, rdy}, 8'h01);
    rd(6'h30, v); check("R10 data zero", v, 8'h00);
    wr(6'h00, 8'h40);
    @(negedge clk); pd_n = 1'b1; @(negedge clk);
    rd(6'h30, v); check("R10 swept byte", v, 8'hFF);
    rd(6'h3A, v); check("R10 unswept byte", v, 8'h00);
    wr(6'h00, 8'h70); rd(6'h00, v); check("R10 status cleared", v, 8'h80);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_erase();
    t_bad_confirm();
    t_novpp();
    t_suspend();
    t_vpp_abort_last();
    t_powerdown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule